// File: doc/BRIEF.md
# GF(2^128) Montgomery Field Multiplier

This block multiplies two 128-bit elements of the binary field defined by g(x) = x^128 + x^127 + x^126 + x^121 + 1. It returns op_a·op_b·x^-128 mod g(x), where bit i of every 128-bit word is the coefficient of x^i. When both operands are in Montgomery form (scaled by x^128), the result is their product in Montgomery form. Chained multiplies therefore need no conversion between steps. Typical use is repeated accumulate-and-multiply in a polynomial hash, with the key kept in Montgomery form.

A single 64×64 carry-less multiplier is shared across six sequential steps. Four steps build the 256-bit product from the operand halves with schoolbook multiplication. Two folding steps then cancel the low 128 bits by multiplying with the constant 0xC200000000000000, which is the upper 64 coefficients of g(x). The upper 128 bits that remain are the answer. A request is a one-cycle `start_i` while `busy_o` is low. The result appears with a one-cycle `done_o` pulse.

Top module: `gf128_mont_mul`

## Requirements
- R1: `result_o` equals op_a·op_b·x^-128 mod g(x), where g(x) = x^128+x^127+x^126+x^121+1 and bit i of each word is the coefficient of x^i.
- R2: Multiplying any operand by 128'hC2000000_00000000_00000000_00000001 (x^128 mod g), in either operand position, returns that operand unchanged.
- R3: A zero operand in either position gives a zero result.
- R4: A start accepted at clock edge k raises `busy_o` after edge k. `busy_o` falls and `done_o` rises after edge k+6, so `done_o` and `busy_o` are never high together.
- R5: `done_o` is high for exactly one cycle per accepted request.
- R6: A `start_i` that arrives while `busy_o` is high is ignored. The running result is unaffected and no extra `done_o` follows.
- R7: `result_o` holds its value from one `done_o` pulse until the next.
- R8: After a synchronous active-low reset, `busy_o` = 0, `done_o` = 0 and `result_o` = 0.
- R9: Operands are captured on the accepting edge. Changes on `op_a_i`/`op_b_i` while busy do not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request; accepted when `busy_o` is low |
| op_a_i | input | 128 | First operand |
| op_b_i | input | 128 | Second operand |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | One-cycle pulse: `result_o` is new |
| result_o | output | 128 | op_a·op_b·x^-128 mod g(x) |

## Verification
The bench compares results against a bit-serial Montgomery reference. That reference adds shifted copies of op_a and divides by x once per coefficient, so it shares no folding logic with the design. A swapped or mis-indexed cross term, or a wrong word combination in the folds, would make the result miss the reference on dense operands. The same faults would break the identity under x^128 mod g.

Zero operands, the all-ones word and the identity element test the edges of the fold arithmetic. A late or early step counter would show up as a latency other than six cycles. A design that re-armed on a start arriving while busy would produce a second pulse or a result from the wrong operands. A design that read its operand inputs live instead of latching them would fail when those inputs change mid-operation.

// File: rtl/gf128_mont_pkg.sv
// Shared constants and step encoding for the GF(2^128) Montgomery multiplier.
// Assumes the field polynomial x^128 + x^127 + x^126 + x^121 + 1.
package gf128_mont_pkg;
    localparam int unsigned HALF_W  = 64;
    localparam int unsigned FULL_W  = 2 * HALF_W;
    localparam int unsigned N_STEPS = 6;
    localparam int unsigned STEP_W  = $clog2(N_STEPS);

    // Upper 64 coefficients of the modulus: x^127, x^126, x^121 -> bits 63,62,57.
    localparam logic [HALF_W-1:0] FOLD_K = 64'hC200_0000_0000_0000;

    // Sequence of work on the shared multiplier; order matters for the folds.
    typedef enum logic [STEP_W-1:0] {
        ST_LL = 3'd0,   // a_lo * b_lo
        ST_LH = 3'd1,   // a_lo * b_hi
        ST_HL = 3'd2,   // a_hi * b_lo
        ST_HH = 3'd3,   // a_hi * b_hi
        ST_F1 = 3'd4,   // K * P0
        ST_F2 = 3'd5    // K * (P1 ^ T0)
    } step_e;
endpackage

// File: rtl/gf128_clmul.sv
// Combinational carry-less multiplier of two W-bit polynomials.
// Assumes nothing about operand values; output is the 2W-bit product.
module gf128_clmul #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0]   x_i,
    input  logic [W-1:0]   y_i,
    output logic [2*W-1:0] p_o
);
    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] pp [W];

    // One shifted copy of x per set bit of y.
    for (genvar i = 0; i < W; i++) begin : g_row
        assign pp[i] = y_i[i] ? ({{W{1'b0}}, x_i} << i) : '0;
    end

    // XOR-sum of all partial products.
    always_comb begin
        p_o = '0;
        for (int i = 0; i < W; i++) begin
            p_o = p_o ^ pp[i];
        end
    end
endmodule

// File: rtl/gf128_mont_ctrl.sv
// Sequencer: accepts a request when idle, walks the six multiplier steps,
// then pulses done. Starts seen while busy are dropped.
module gf128_mont_ctrl
    import gf128_mont_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    output logic  accept_o,
    output logic  busy_o,
    output step_e step_o,
    output logic  done_o
);
    step_e step_q;
    logic  busy_q;
    logic  done_q;

    assign accept_o = start_i && !busy_q;

    // Step counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            step_q <= ST_LL;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept_o) begin
                busy_q <= 1'b1;
                step_q <= ST_LL;
            end else if (busy_q) begin
                if (step_q == ST_F2) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    step_q <= ST_LL;
                end else begin
                    step_q <= step_e'(step_q + 3'd1);
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign step_o = step_q;
    assign done_o = done_q;
endmodule

// File: rtl/gf128_mont_dp.sv
// Datapath: latches operands, steers halves into the shared multiplier,
// accumulates the 256-bit product and applies the two Montgomery folds.
// Assumes the sequencer presents steps in package order, one per cycle.
module gf128_mont_dp
    import gf128_mont_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              busy_i,
    input  step_e             step_i,
    input  logic [FULL_W-1:0] op_a_i,
    input  logic [FULL_W-1:0] op_b_i,
    input  logic [FULL_W-1:0] prod_i,
    output logic [HALF_W-1:0] mul_x_o,
    output logic [HALF_W-1:0] mul_y_o,
    output logic [FULL_W-1:0] result_o
);
    logic [FULL_W-1:0] a_q, b_q;
    logic [FULL_W-1:0] lo_q, mi_q, hi_q, t_q;
    logic [FULL_W-1:0] res_q;
    logic [HALF_W-1:0] w0, w1, w2, w3;

    // 64-bit words of the 256-bit product.
    always_comb begin
        w0 = lo_q[HALF_W-1:0];
        w1 = lo_q[FULL_W-1:HALF_W] ^ mi_q[HALF_W-1:0];
        w2 = hi_q[HALF_W-1:0]      ^ mi_q[FULL_W-1:HALF_W];
        w3 = hi_q[FULL_W-1:HALF_W];
    end

    // Operand steering for the shared multiplier.
    always_comb begin
        unique case (step_i)
            ST_LL:   begin mul_x_o = a_q[HALF_W-1:0];      mul_y_o = b_q[HALF_W-1:0];      end
            ST_LH:   begin mul_x_o = a_q[HALF_W-1:0];      mul_y_o = b_q[FULL_W-1:HALF_W]; end
            ST_HL:   begin mul_x_o = a_q[FULL_W-1:HALF_W]; mul_y_o = b_q[HALF_W-1:0];      end
            ST_HH:   begin mul_x_o = a_q[FULL_W-1:HALF_W]; mul_y_o = b_q[FULL_W-1:HALF_W]; end
            ST_F1:   begin mul_x_o = w0;                   mul_y_o = FOLD_K;               end
            ST_F2:   begin mul_x_o = w1 ^ t_q[HALF_W-1:0]; mul_y_o = FOLD_K;               end
            default: begin mul_x_o = '0;                   mul_y_o = '0;                   end
        endcase
    end

    // Operand capture on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (accept_i) begin
            a_q <= op_a_i;
            b_q <= op_b_i;
        end
    end

    // Product accumulation, fold term and final result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            mi_q  <= '0;
            hi_q  <= '0;
            t_q   <= '0;
            res_q <= '0;
        end else if (busy_i) begin
            unique case (step_i)
                ST_LL: lo_q <= prod_i;
                ST_LH: mi_q <= prod_i;
                ST_HL: mi_q <= mi_q ^ prod_i;
                ST_HH: hi_q <= prod_i;
                ST_F1: t_q  <= prod_i;
                ST_F2: res_q <= {w3 ^ w1 ^ t_q[HALF_W-1:0] ^ prod_i[FULL_W-1:HALF_W],
                                 w2 ^ w0 ^ t_q[FULL_W-1:HALF_W] ^ prod_i[HALF_W-1:0]};
                default: ;
            endcase
        end
    end

    assign result_o = res_q;
endmodule

// File: rtl/gf128_mont_mul.sv
// Top: GF(2^128) Montgomery multiplier, result = a*b*x^-128 mod g.
// Six cycles per operation over one shared 64x64 carry-less multiplier.
module gf128_mont_mul
    import gf128_mont_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [FULL_W-1:0] op_a_i,
    input  logic [FULL_W-1:0] op_b_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [FULL_W-1:0] result_o
);
    logic              accept;
    step_e             step;
    logic [HALF_W-1:0] mul_x, mul_y;
    logic [FULL_W-1:0] prod;

    gf128_mont_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .busy_o   (busy_o),
        .step_o   (step),
        .done_o   (done_o)
    );

    gf128_mont_dp u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .busy_i   (busy_o),
        .step_i   (step),
        .op_a_i   (op_a_i),
        .op_b_i   (op_b_i),
        .prod_i   (prod),
        .mul_x_o  (mul_x),
        .mul_y_o  (mul_y),
        .result_o (result_o)
    );

    gf128_clmul #(.W(HALF_W)) u_clmul (
        .x_i (mul_x),
        .y_i (mul_y),
        .p_o (prod)
    );
endmodule

// File: rtl/gf128_mont_mul_chk.sv
// Protocol checker for gf128_mont_mul, attached by bind.
module gf128_mont_mul_chk
    import gf128_mont_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [FULL_W-1:0] result_o
);
    localparam int unsigned CW = STEP_W + 1;
    logic [CW-1:0] since_go;

    // Edges elapsed since the last accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_go <= '0;
        else if (start_i && !busy_o) since_go <= '0;
        else if (busy_o)             since_go <= since_go + 1'b1;
    end

    a_r4_busy_after_go: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    a_r4_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (since_go == CW'(N_STEPS)));
    a_r4_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));
endmodule

bind gf128_mont_mul gf128_mont_mul_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/gf128_mont_mul_test.sv
// Directed bench for gf128_mont_mul against a bit-serial reference.
module gf128_mont_mul_test;
    localparam logic [127:0] MONT_ONE = 128'hC200_0000_0000_0000_0000_0000_0000_0001;
    localparam logic [127:0] G_LOW    = 128'hC200_0000_0000_0000_0000_0000_0000_0001;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [127:0] op_a_i = '0;
    logic [127:0] op_b_i = '0;
    logic         busy_o, done_o;
    logic [127:0] result_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #2.5 clk = ~clk;

    gf128_mont_mul uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .op_a_i(op_a_i), .op_b_i(op_b_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    // Reference: accumulate a*b_i, divide by x after each coefficient.
    function automatic logic [127:0] ref_mul(input logic [127:0] a, input logic [127:0] b);
        logic [127:0] acc = '0;
        for (int i = 0; i < 128; i++) begin
            if (b[i]) acc = acc ^ a;
            if (acc[0]) acc = ((acc ^ G_LOW) >> 1) | (128'b1 << 127);
            else        acc = acc >> 1;
        end
        return acc;
    endfunction

    function automatic logic [63:0] xs64(input logic [63:0] s);
        logic [63:0] v = s;
        v = v ^ (v << 13);
        v = v ^ (v >> 7);
        v = v ^ (v << 17);
        return v;
    endfunction

    task automatic next_word(output logic [127:0] w);
        seed = xs64(seed);
        w[127:64] = seed;
        seed = xs64(seed);
        w[63:0] = seed;
    endtask

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One request; returns the result and edges from acceptance to done.
    task automatic do_mul(input logic [127:0] a, input logic [127:0] b,
                          output logic [127:0] r, output int lat);
        @(negedge clk);
        op_a_i = a; op_b_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        r = result_o;
    endtask

    task automatic t_reset;
        chk("R8 busy", {127'b0, busy_o}, '0);
        chk("R8 done", {127'b0, done_o}, '0);
        chk("R8 result", result_o, '0);
    endtask

    task automatic t_random;
        logic [127:0] a, b, r;
        int lat;
        for (int k = 0; k < 8; k++) begin
            next_word(a);
            next_word(b);
            do_mul(a, b, r, lat);
            chk("R1 product", r, ref_mul(a, b));
            chk("R4 latency", 128'(lat), 128'd6);
        end
        do_mul('1, '1, r, lat);
        chk("R1 all ones", r, ref_mul('1, '1));
        do_mul(128'd1, 128'd1, r, lat);
        chk("R1 one*one", r, ref_mul(128'd1, 128'd1));
    endtask

    task automatic t_identity;
        logic [127:0] a, r;
        int lat;
        for (int k = 0; k < 3; k++) begin
            next_word(a);
            do_mul(a, MONT_ONE, r, lat);
            chk("R2 a*one", r, a);
            do_mul(MONT_ONE, a, r, lat);
            chk("R2 one*a", r, a);
        end
        do_mul(MONT_ONE, MONT_ONE, r, lat);
        chk("R2 one*one", r, MONT_ONE);
    endtask

    task automatic t_zero;
        logic [127:0] a, r;
        int lat;
        next_word(a);
        do_mul(a, '0, r, lat);
        chk("R3 a*0", r, '0);
        do_mul('0, a, r, lat);
        chk("R3 0*a", r, '0);
    endtask

    task automatic t_pulse_hold;
        logic [127:0] a, b, r;
        int lat;
        next_word(a);
        next_word(b);
        do_mul(a, b, r, lat);
        chk("R4 busy low at done", {127'b0, busy_o}, '0);
        @(negedge clk);
        chk("R5 done one cycle", {127'b0, done_o}, '0);
        for (int k = 0; k < 5; k++) @(negedge clk);
        chk("R7 result held", result_o, r);
    endtask

    task automatic t_busy_start;
        logic [127:0] a, b, c, d, r;
        int lat;
        int extra;
        next_word(a); next_word(b); next_word(c); next_word(d);
        @(negedge clk);
        op_a_i = a; op_b_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        op_a_i = c; op_b_i = d; start_i = 1'b1;  // arrives while busy
        @(negedge clk);
        start_i = 1'b0;
        lat = 2;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        r = result_o;
        chk("R6 result of first request", r, ref_mul(a, b));
        chk("R6 latency unchanged", 128'(lat), 128'd6);
        extra = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (done_o || busy_o) extra++;
        end
        chk("R6 no second operation", 128'(extra), '0);
    endtask

    task automatic t_capture;
        logic [127:0] a, b, c, r;
        int lat;
        next_word(a); next_word(b); next_word(c);
        @(negedge clk);
        op_a_i = a; op_b_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        op_a_i = c; op_b_i = ~c;
        lat = 0;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        r = result_o;
        chk("R9 operands latched", r, ref_mul(a, b));
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #(5ns * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_random();
        t_identity();
        t_zero();
        t_pulse_hold();
        t_busy_start();
        t_capture();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule